// File: doc/BRIEF.md
# Low-Side Driver Load Fault Protection Sequencer

This block sits between the on/off commands of a low-side gate driver and its gate outputs. There is one protection channel per output. Every channel drives its gate from the command. It watches a digital comparator that reports whether the drain is above the fault reference. From that it decides whether the load is shorted or open. A short can only be seen while the transistor conducts. An open load can only be seen while it is off. Each test waits for a settling interval after the drive level changes, so that switching transients are not mistaken for faults.

The reaction to a short is chosen at build time. Latch mode keeps the gate off until the command is withdrawn and given again. Retry mode switches the gate into a sparse pulse pattern that re-tests the load on every pulse. It goes back to continuous drive once the short is gone. An over-voltage or under-voltage flag on the supply forces every gate off for as long as it is present. It also hides the load-fault flags and freezes all testing.

Top module: `load_fault_guard`

## Requirements
- R1: While the synchronous active-low reset is asserted, every gate output and every short and open flag is 0.
- R2: With no fault, the gate of a channel goes high in the cycle after the clock edge that samples its command high. It goes low in the cycle after the edge that samples the command low.
- R3: A short is declared at the first edge where the drive has been continuously on for SETTLE_CYC+1 cycles and the drain input reads 1. A drain that reads 1 only before that point declares nothing.
- R4: In latch mode (RETRY_EN=0) a declared short sets the short flag and turns the gate off. The gate stays off while the command stays high. Sampling the command low and then high again clears the flag and drives the gate.
- R5: In retry mode (RETRY_EN=1) a declared short turns the gate off for BACKOFF_CYC+1 cycles and then on for SETTLE_CYC+1 cycles. It re-tests at the end of that window, giving a period of BACKOFF_CYC+SETTLE_CYC+2 cycles. The short flag stays 1 throughout.
- R6: In retry mode, a re-test that finds the drain at 0 clears the short flag, and the gate stays on continuously from then on.
- R7: The open flag is written only while the channel is off and SETTLE_CYC+1 cycles have passed since the drive went low. It is then written each cycle with the inverse of the drain input (drain 0 means open). A low drain while the gate is on never sets it.
- R8: A set open flag clears at the first tested edge where the drain reads 1 again.
- R9: While either supply fault input is 1, every gate output and every flag output reads 0 in the same cycle. No test runs, and the settling interval restarts when the supply fault ends. Flags held before the fault reappear once it ends.
- R10: Channels are independent: a fault on one channel changes no other channel's gate or flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cmdOn | input | NUM_CH | Per-channel on command (1 = on) |
| drainHigh | input | NUM_CH | Per-channel comparator: drain above fault reference |
| overBat | input | 1 | Supply over-voltage flag |
| underBat | input | 1 | Supply under-voltage flag |
| gateEn | output | NUM_CH | Per-channel gate drive |
| shortFlt | output | NUM_CH | Per-channel short-load flag |
| openFlt | output | NUM_CH | Per-channel open-load flag |

## Verification
The assertions assume that the command, comparator and supply-fault inputs are synchronous to the clock and stable at each sampling edge. They also assume that the comparator reflects the load as seen at the drain. The bench changes every input only just after a rising edge. It models each load as healthy, shorted or open by setting the drain level to match the drive state. A sweep turns each channel on alone, and directed sequences place short, open, glitch and supply-fault events at exact offsets from the drive changes. The settling and back-off intervals are shrunk to a few cycles, so that every boundary edge can be counted arithmetically.

// File: rtl/lfg_pkg.sv
package lfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DRIVE   = 3'd1,
    ST_TRIPPED = 3'd2,
    ST_BACKOFF = 3'd3,
    ST_PROBE   = 3'd4
  } chanMode_t;

  // control -> datapath
  typedef struct packed {
    logic restart;
  } timerStrb_t;

  // datapath -> control
  typedef struct packed {
    logic settled;
    logic waitDone;
  } timerStat_t;

endpackage

// File: rtl/lfg_timer.sv
module lfg_timer
  import lfg_pkg::*;
#(
  parameter int SETTLE_CYC  = 3000,
  parameter int BACKOFF_CYC = 93000
) (
  input  logic       clk,
  input  logic       rstN,
  input  timerStrb_t strb,
  output timerStat_t stat
);

  localparam int MAX_CNT = (SETTLE_CYC > BACKOFF_CYC) ? SETTLE_CYC : BACKOFF_CYC;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] SETTLE_V  = CNT_W'(SETTLE_CYC);
  localparam logic [CNT_W-1:0] BACKOFF_V = CNT_W'(BACKOFF_CYC);
  localparam logic [CNT_W-1:0] MAX_V     = CNT_W'(MAX_CNT);

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.restart) begin
      cntQ <= '0;
    end else if (cntQ < MAX_V) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  always_comb begin
    stat.settled  = (cntQ >= SETTLE_V);
    stat.waitDone = (cntQ >= BACKOFF_V);
  end

  // R3: a restart request always brings the interval back to zero
  p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (cntQ == '0));

  // R5: the count saturates and never wraps past its limit
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == MAX_V && !strb.restart) |=> (cntQ == MAX_V));

endmodule

// File: rtl/lfg_ctrl.sv
module lfg_ctrl
  import lfg_pkg::*;
#(
  parameter bit RETRY_EN = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdOn,
  input  logic       drainHigh,
  input  logic       batFault,
  input  timerStat_t stat,
  output timerStrb_t strb,
  output logic       drive,
  output logic       shortQ,
  output logic       openQ
);

  chanMode_t modeQ, modeNxt;
  logic      shortNxt, openNxt;
  logic      testOk, waitOk, keepTimer;

  assign testOk = stat.settled && !batFault;
  assign waitOk = stat.waitDone && !batFault;
  assign drive  = (modeQ == ST_DRIVE) || (modeQ == ST_PROBE);

  always_comb begin
    modeNxt  = modeQ;
    shortNxt = shortQ;
    openNxt  = openQ;
    unique case (modeQ)
      ST_IDLE: begin
        if (cmdOn) begin
          modeNxt  = ST_DRIVE;
          shortNxt = 1'b0;
        end else if (testOk) begin
          openNxt = ~drainHigh;
        end
      end
      ST_DRIVE: begin
        if (!cmdOn) begin
          modeNxt = ST_IDLE;
        end else if (testOk && drainHigh) begin
          shortNxt = 1'b1;
          modeNxt  = RETRY_EN ? ST_BACKOFF : ST_TRIPPED;
        end
      end
      ST_TRIPPED: begin
        if (!cmdOn) modeNxt = ST_IDLE;
      end
      ST_BACKOFF: begin
        if (!cmdOn)      modeNxt = ST_IDLE;
        else if (waitOk) modeNxt = ST_PROBE;
      end
      ST_PROBE: begin
        if (!cmdOn) begin
          modeNxt = ST_IDLE;
        end else if (testOk) begin
          if (drainHigh) begin
            modeNxt = ST_BACKOFF;
          end else begin
            modeNxt  = ST_DRIVE;
            shortNxt = 1'b0;
          end
        end
      end
      default: modeNxt = ST_IDLE;
    endcase
    // probe -> drive keeps the gate on, so the interval keeps running
    keepTimer    = (modeQ == ST_PROBE) && (modeNxt == ST_DRIVE);
    strb.restart = batFault || ((modeNxt != modeQ) && !keepTimer);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= ST_IDLE;
      shortQ <= 1'b0;
      openQ  <= 1'b0;
    end else begin
      modeQ  <= modeNxt;
      shortQ <= shortNxt;
      openQ  <= openNxt;
    end
  end

  // R3: a short appears only after a settled, driven cycle with a high drain
  p_short_after_settle_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shortQ) |-> $past(stat.settled && drive && drainHigh));

  // R7: an open load appears only after a settled, undriven cycle with a low drain
  p_open_when_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(openQ) |-> $past(stat.settled && !drive && !drainHigh));

  // R9: no new flag is raised from an edge that saw a supply fault
  p_no_flag_in_bat_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(batFault) |-> (!$rose(shortQ) && !$rose(openQ)));

  generate
    if (RETRY_EN) begin : g_retry_chk
      // R5: the short flag holds through the back-off phase
      p_flag_holds_backoff_r5: assert property (@(posedge clk) disable iff (!rstN)
        (modeQ == ST_BACKOFF && cmdOn) |=> shortQ);
    end else begin : g_latch_chk
      // R4: a tripped channel stays undriven while the command is held
      p_tripped_stays_off_r4: assert property (@(posedge clk) disable iff (!rstN)
        (modeQ == ST_TRIPPED && cmdOn) |=> !drive);
    end
  endgenerate

endmodule

// File: rtl/load_fault_guard.sv
module load_fault_guard
  import lfg_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int SETTLE_CYC  = 3000,
  parameter int BACKOFF_CYC = 93000,
  parameter bit RETRY_EN    = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] cmdOn,
  input  logic [NUM_CH-1:0] drainHigh,
  input  logic              overBat,
  input  logic              underBat,
  output logic [NUM_CH-1:0] gateEn,
  output logic [NUM_CH-1:0] shortFlt,
  output logic [NUM_CH-1:0] openFlt
);

  logic              batFault;
  logic [NUM_CH-1:0] driveVec, shortVec, openVec;

  assign batFault = overBat | underBat;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      timerStrb_t strb;
      timerStat_t stat;

      lfg_timer #(
        .SETTLE_CYC (SETTLE_CYC),
        .BACKOFF_CYC(BACKOFF_CYC)
      ) timer_i (
        .clk (clk),
        .rstN(rstN),
        .strb(strb),
        .stat(stat)
      );

      lfg_ctrl #(
        .RETRY_EN(RETRY_EN)
      ) ctrl_i (
        .clk      (clk),
        .rstN     (rstN),
        .cmdOn    (cmdOn[ch]),
        .drainHigh(drainHigh[ch]),
        .batFault (batFault),
        .stat     (stat),
        .strb     (strb),
        .drive    (driveVec[ch]),
        .shortQ   (shortVec[ch]),
        .openQ    (openVec[ch])
      );
    end
  endgenerate

  assign gateEn   = driveVec & {NUM_CH{~batFault}};
  assign shortFlt = shortVec & {NUM_CH{~batFault}};
  assign openFlt  = openVec  & {NUM_CH{~batFault}};

  // R1: reset leaves every output quiet on the following cycle
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (gateEn == '0 && shortFlt == '0 && openFlt == '0));

endmodule

// File: tb/load_fault_guard_tb_top.sv
module load_fault_guard_tb_top;

  localparam int NCH = 6;
  localparam int SET = 4;
  localparam int BOF = 12;

  logic           clk = 1'b0;
  logic           rstN;
  logic [NCH-1:0] cmd, drain;
  logic           ovb, unb;
  logic [NCH-1:0] gateL, shortL, openL;
  logic [NCH-1:0] gateR, shortR, openR;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  load_fault_guard #(.NUM_CH(NCH), .SETTLE_CYC(SET), .BACKOFF_CYC(BOF), .RETRY_EN(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .cmdOn(cmd), .drainHigh(drain), .overBat(ovb), .underBat(unb),
    .gateEn(gateL), .shortFlt(shortL), .openFlt(openL));

  load_fault_guard #(.NUM_CH(NCH), .SETTLE_CYC(SET), .BACKOFF_CYC(BOF), .RETRY_EN(1'b1)) dut_rtry_i (
    .clk(clk), .rstN(rstN), .cmdOn(cmd), .drainHigh(drain), .overBat(ovb), .underBat(unb),
    .gateEn(gateR), .shortFlt(shortR), .openFlt(openR));

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hiCnt, flCnt, latHi;
    rstN = 1'b0; cmd = '0; drain = '1; ovb = 1'b0; unb = 1'b0;
    tick(3);
    // R1
    check("R1", "latch outputs", int'({gateL, shortL, openL}), 0);
    check("R1", "retry outputs", int'({gateR, shortR, openR}), 0);
    rstN = 1'b1;
    tick(SET + 2);

    // R2 sweep: each channel alone, healthy load
    for (int ch = 0; ch < NCH; ch++) begin
      cmd = NCH'(1) << ch; drain = ~cmd;
      tick();
      check("R2", "gate on latch", int'(gateL), int'(cmd));
      check("R2", "gate on retry", int'(gateR), int'(cmd));
      tick(SET + 4);
      check("R7", "no open while on", int'(openL | openR), 0);
      check("R3", "no short on healthy", int'(shortL | shortR), 0);
      cmd = '0; drain = '1;
      tick();
      check("R2", "gate off", int'(gateL | gateR), 0);
      tick(SET + 2);
    end

    // R7 / R8: open load on channel 1 after turn-off
    cmd[1] = 1'b1; drain[1] = 1'b0;
    tick(3);
    cmd[1] = 1'b0;
    tick(SET + 1);
    check("R7", "open before settle", int'(openL[1]), 0);
    tick();
    check("R7", "open after settle latch", int'(openL[1]), 1);
    check("R7", "open after settle retry", int'(openR[1]), 1);
    check("R10", "open isolated", int'(openL & ~6'b000010), 0);
    drain[1] = 1'b1;
    tick();
    check("R8", "open clears", int'(openL[1] | openR[1]), 0);
    tick(SET + 2);

    // R3 boundary: drain high only before the test point on channel 3
    cmd[3] = 1'b1; drain[3] = 1'b1;
    tick(1 + SET);
    drain[3] = 1'b0;
    tick(4);
    check("R3", "glitch ignored latch", int'({gateL[3], shortL[3]}), 2);
    check("R3", "glitch ignored retry", int'({gateR[3], shortR[3]}), 2);
    cmd[3] = 1'b0; drain[3] = 1'b1;
    tick(SET + 2);

    // R3: persistent short on channel 2, channel 0 healthy on
    cmd[0] = 1'b1; drain[0] = 1'b0;
    cmd[2] = 1'b1; drain[2] = 1'b1;
    tick();
    check("R3", "short ch gate on", int'(gateL[2] & gateR[2]), 1);
    tick(SET);
    check("R3", "not yet declared", int'({shortL[2], shortR[2], gateL[2]}), 1);
    tick();
    check("R3", "declared latch", int'(shortL[2]), 1);
    check("R3", "declared retry", int'(shortR[2]), 1);
    check("R10", "gates latch", int'(gateL), 1);
    check("R10", "gates retry", int'(gateR), 1);

    // R4 / R5: observe two retry periods
    hiCnt = 0; flCnt = 0; latHi = 0;
    for (int k = 1; k <= 2 * (BOF + SET + 2); k++) begin
      tick();
      if (gateR[2]) hiCnt++;
      if (shortR[2]) flCnt++;
      if (gateL[2]) latHi++;
      if (k == BOF) check("R5", "still backing off", int'(gateR[2]), 0);
      if (k == BOF + 1) check("R5", "probe starts", int'(gateR[2]), 1);
    end
    check("R5", "on cycles in two periods", hiCnt, 2 * (SET + 1));
    check("R5", "flag held", flCnt, 2 * (BOF + SET + 2));
    check("R4", "latched gate held off", latHi, 0);

    // R6: short removed; next probe restores drive
    drain[2] = 1'b0;
    tick(BOF + SET + 1);
    check("R6", "flag before re-test", int'(shortR[2]), 1);
    tick();
    check("R6", "flag cleared", int'(shortR[2]), 0);
    tick(5);
    check("R6", "continuous drive", int'(gateR[2]), 1);
    check("R4", "latch still off", int'({gateL[2], shortL[2]}), 1);

    // R4: re-arm by low then high
    cmd[2] = 1'b0; drain[2] = 1'b1;
    tick();
    check("R4", "flag held while off", int'({gateL[2], shortL[2]}), 1);
    cmd[2] = 1'b1; drain[2] = 1'b0;
    tick();
    check("R4", "re-armed", int'({gateL[2], shortL[2]}), 2);
    cmd = '0; drain = '1;
    tick(SET + 2);

    // R9: supply faults
    cmd[4] = 1'b1; drain[4] = 1'b0;
    tick();
    ovb = 1'b1; drain[4] = 1'b1; drain[5] = 1'b0;
    #1;
    check("R9", "gate masked latch", int'(gateL), 0);
    check("R9", "gate masked retry", int'(gateR), 0);
    tick(10);
    check("R9", "no flags latch", int'(shortL | openL), 0);
    check("R9", "no flags retry", int'(shortR | openR), 0);
    ovb = 1'b0;
    #1;
    check("R9", "gate back", int'(gateL[4] & gateR[4]), 1);
    tick(SET);
    check("R9", "settle restarted", int'({shortL[4], openL[5], shortR[4], openR[5]}), 0);
    tick();
    check("R9", "tests resume latch", int'({shortL[4], openL[5]}), 3);
    check("R9", "tests resume retry", int'({shortR[4], openR[5]}), 3);
    unb = 1'b1;
    #1;
    check("R9", "flags hidden", int'(shortL | openL | shortR | openR), 0);
    tick(2);
    unb = 1'b0;
    #1;
    check("R9", "flags reappear", int'({shortL[4], openL[5], shortR[4], openR[5]}), 15);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule